// File: doc/BRIEF.md
# Snoop Issue and Bus Backoff Sequencer

This block sits on the system side of a bus shared by a write-back caching processor and other masters. When another master needs to check a line held in the processor's cache, it hands the block an address and a flag that says whether the line is to be invalidated. The block takes the processor's address bus away with a hold, presents the snoop address with an external-address strobe, and samples the processor's modified-line hit indication at a fixed latency.

On a miss the block releases the hold and reports the snoop as done. On a hit it lets the processor write the dirty line back, and it acts as the memory target for that write-back. If a processor burst was already in flight when the hit was seen, the block pulses a back-off for one clock. The back-off aborts the burst, so the write-back is the first cycle the processor issues. The processor re-runs the aborted burst afterwards. A small tracker follows address strobes, last-beat and ready on the bus to decide whether a processor cycle is open.

Top module: `snoop_backoff_ctrl`

## Requirements
- R1: While reset is held and right after release, `ahold_o`=0, `eads_n_o`=1, `boff_n_o`=1, `wb_brdy_n_o`=1, `snp_done_o`=0 and `snp_ready_o`=1.
- R2: A request sampled with `snp_req_i`=1 while `snp_ready_o`=1 is accepted. `ahold_o` is 1 and `snp_ready_o` is 0 in the next cycle. `snp_ready_o` returns to 1 only in the cycle after the `snp_done_o` pulse.
- R3: `eads_n_o` is 0 for exactly one cycle. That cycle is the third cycle of the hold (two full clocks after `ahold_o` first reads 1). During it `snp_addr_o` carries the accepted address, `addr_oe_o`=1 and `inv_o` equals the accepted invalidate flag. `inv_o` is 0 in every other cycle.
- R4: `hitm_n_i` is sampled only at the end of the second cycle after the strobe cycle. A low level in any other cycle has no effect on the outcome.
- R5: If the sample is 1 (miss), the next cycle has `snp_done_o`=1, `snp_hit_o`=0, `ahold_o`=0 and `boff_n_o`=1. The block is then idle.
- R6: If the sample is 0 (hit) and a processor cycle is open, `boff_n_o` is 0 for exactly the next cycle, with `ahold_o` still 1.
- R7: On a hit, `ahold_o` falls in the cycle after the back-off cycle, or in the cycle after the sample when no back-off is issued. The following cycle is the first one in which the write-back address strobe is accepted.
- R8: After the write-back strobe (`ads_n_i`=0) is seen, `wb_brdy_n_o` is 0 every cycle until a cycle with `blast_n_i`=0. The next cycle has `snp_done_o`=1 and `snp_hit_o`=1.
- R9: A processor cycle opens on `ads_n_i`=0 outside the write-back. It closes when `blast_n_i` and the bus ready (`brdy_n_i` AND `wb_brdy_n_o`) are both 0 in one cycle, or when a back-off is issued.
- R10: On a hit with no open processor cycle, no back-off is issued (`boff_n_o` stays 1).
- R11: A request presented while `snp_ready_o`=0 is dropped. It does not change the address or flag of the snoop in progress, and it does not start another snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snp_req_i | input | 1 | Snoop request from another master |
| snp_addr_i | input | AW | Address to snoop |
| snp_inv_i | input | 1 | Invalidate the line when the snoop completes |
| snp_ready_o | output | 1 | Block is idle and will take a request |
| snp_done_o | output | 1 | One-cycle pulse: snoop finished |
| snp_hit_o | output | 1 | Snoop found a modified line (valid with done) |
| ads_n_i | input | 1 | Processor address strobe, active low |
| blast_n_i | input | 1 | Processor last-beat indication, active low |
| brdy_n_i | input | 1 | Burst ready from the memory controller, active low |
| hitm_n_i | input | 1 | Processor modified-line hit, active low |
| ahold_o | output | 1 | Address hold to the processor |
| eads_n_o | output | 1 | External address strobe, active low |
| inv_o | output | 1 | Invalidate qualifier for the snoop |
| snp_addr_o | output | AW | Snoop address driven to the processor |
| addr_oe_o | output | 1 | Enable for driving the snoop address |
| boff_n_o | output | 1 | Back-off to the processor, active low |
| wb_brdy_n_o | output | 1 | Ready for write-back beats, active low |

## Verification
The checker watches the hold and strobe ordering on every cycle. It also checks the one-clock width of the strobe and of the back-off, that a back-off follows a sampled hit and drops the hold in the next cycle, and that write-back ready and done appear only with the bus released. Whether the outstanding-cycle tracker closes correctly on completion or on back-off only shows across the bench's back-to-back scenarios, where a wrongly open cycle turns into a spurious back-off. The same holds for a mistimed hit sample being ignored, a request while busy being dropped, and the exact beat count of the write-back.

// File: rtl/snpbo_pkg.sv
package snpbo_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOLD,
    ST_PROBE,
    ST_LAT,
    ST_BACKOFF,
    ST_GAP,
    ST_WB_ADDR,
    ST_WB_DATA,
    ST_DONE
  } snp_state_e;
endpackage

// File: rtl/snp_bus_tracker.sv
module snp_bus_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic ads_n_i,
  input  logic blast_n_i,
  input  logic bus_brdy_n_i,
  input  logic boff_n_i,
  input  logic wb_active_i,
  output logic busy_now_o
);
  logic open_q, open_d;
  logic start_c, close_c;

  assign start_c = ~ads_n_i & ~wb_active_i;
  assign close_c = ~blast_n_i & ~bus_brdy_n_i;

  always_comb begin
    open_d = open_q;
    if (!boff_n_i)    open_d = 1'b0;
    else if (start_c) open_d = 1'b1;
    else if (close_c) open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  // a cycle finishing in this very clock no longer needs to be aborted
  assign busy_now_o = open_q & ~close_c;
endmodule

// File: rtl/snp_req_capture.sv
module snp_req_capture #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          inv_i,
  output logic [AW-1:0] addr_o,
  output logic          inv_o
);
  logic [AW-1:0] addr_q;
  logic          inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      inv_q  <= 1'b0;
    end else if (load_i) begin
      addr_q <= addr_i;
      inv_q  <= inv_i;
    end
  end

  assign addr_o = addr_q;
  assign inv_o  = inv_q;
endmodule

// File: rtl/snp_sequencer.sv
module snp_sequencer
  import snpbo_pkg::*;
#(
  parameter int HOLD_CLKS = 2,
  parameter int HITM_DLY  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic hitm_n_i,
  input  logic busy_now_i,
  input  logic ads_n_i,
  input  logic blast_n_i,
  output logic accept_o,
  output logic ready_o,
  output logic ahold_o,
  output logic probe_o,
  output logic boff_n_o,
  output logic wb_brdy_n_o,
  output logic wb_active_o,
  output logic done_o,
  output logic hit_o
);
  localparam int MAXD = (HOLD_CLKS > HITM_DLY) ? HOLD_CLKS : HITM_DLY;
  localparam int CW   = (MAXD < 2) ? 1 : $clog2(MAXD);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CLKS - 1);
  localparam logic [CW-1:0] LAT_LAST  = CW'(HITM_DLY - 1);

  snp_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          hit_q, hit_d, hit_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    hit_d  = hit_q;
    hit_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        st_d   = ST_HOLD;
        cnt_d  = HOLD_LAST;
        cnt_en = 1'b1;
        hit_d  = 1'b0;
        hit_en = 1'b1;
      end
      ST_HOLD: begin
        if (cnt_q == '0) st_d = ST_PROBE;
        else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_PROBE: begin
        st_d   = ST_LAT;
        cnt_d  = LAT_LAST;
        cnt_en = 1'b1;
      end
      ST_LAT: begin
        if (cnt_q != '0) begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end else begin
          hit_d  = ~hitm_n_i;
          hit_en = 1'b1;
          if (hitm_n_i)        st_d = ST_DONE;
          else if (busy_now_i) st_d = ST_BACKOFF;
          else                 st_d = ST_GAP;
        end
      end
      ST_BACKOFF: st_d = ST_GAP;
      ST_GAP:     st_d = ST_WB_ADDR;
      ST_WB_ADDR: if (!ads_n_i) st_d = ST_WB_DATA;
      ST_WB_DATA: if (!blast_n_i) st_d = ST_DONE;
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hit_q <= 1'b0;
    else if (hit_en) hit_q <= hit_d;
  end

  assign ready_o     = (st_q == ST_IDLE);
  assign accept_o    = ready_o & req_i;
  assign ahold_o     = (st_q == ST_HOLD) | (st_q == ST_PROBE) |
                       (st_q == ST_LAT)  | (st_q == ST_BACKOFF);
  assign probe_o     = (st_q == ST_PROBE);
  assign boff_n_o    = (st_q != ST_BACKOFF);
  assign wb_brdy_n_o = (st_q != ST_WB_DATA);
  assign wb_active_o = (st_q == ST_GAP) | (st_q == ST_WB_ADDR) | (st_q == ST_WB_DATA);
  assign done_o      = (st_q == ST_DONE);
  assign hit_o       = hit_q;
endmodule

// File: rtl/snoop_backoff_ctrl.sv
module snoop_backoff_ctrl #(
  parameter int AW        = 32,
  parameter int HOLD_CLKS = 2,
  parameter int HITM_DLY  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snp_req_i,
  input  logic [AW-1:0] snp_addr_i,
  input  logic          snp_inv_i,
  output logic          snp_ready_o,
  output logic          snp_done_o,
  output logic          snp_hit_o,
  input  logic          ads_n_i,
  input  logic          blast_n_i,
  input  logic          brdy_n_i,
  input  logic          hitm_n_i,
  output logic          ahold_o,
  output logic          eads_n_o,
  output logic          inv_o,
  output logic [AW-1:0] snp_addr_o,
  output logic          addr_oe_o,
  output logic          boff_n_o,
  output logic          wb_brdy_n_o
);
  logic accept, probe, busy_now, wb_active, inv_q;

  snp_req_capture #(.AW(AW)) i_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .addr_i (snp_addr_i),
    .inv_i  (snp_inv_i),
    .addr_o (snp_addr_o),
    .inv_o  (inv_q)
  );

  snp_bus_tracker i_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .ads_n_i      (ads_n_i),
    .blast_n_i    (blast_n_i),
    .bus_brdy_n_i (brdy_n_i & wb_brdy_n_o),
    .boff_n_i     (boff_n_o),
    .wb_active_i  (wb_active),
    .busy_now_o   (busy_now)
  );

  snp_sequencer #(.HOLD_CLKS(HOLD_CLKS), .HITM_DLY(HITM_DLY)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (snp_req_i),
    .hitm_n_i    (hitm_n_i),
    .busy_now_i  (busy_now),
    .ads_n_i     (ads_n_i),
    .blast_n_i   (blast_n_i),
    .accept_o    (accept),
    .ready_o     (snp_ready_o),
    .ahold_o     (ahold_o),
    .probe_o     (probe),
    .boff_n_o    (boff_n_o),
    .wb_brdy_n_o (wb_brdy_n_o),
    .wb_active_o (wb_active),
    .done_o      (snp_done_o),
    .hit_o       (snp_hit_o)
  );

  assign eads_n_o  = ~probe;
  assign addr_oe_o = probe;
  assign inv_o     = probe & inv_q;
endmodule

// File: rtl/snp_backoff_chk.sv
module snp_backoff_chk (
  input logic clk,
  input logic rst_n,
  input logic snp_ready_o,
  input logic snp_done_o,
  input logic hitm_n_i,
  input logic ahold_o,
  input logic eads_n_o,
  input logic inv_o,
  input logic addr_oe_o,
  input logic boff_n_o,
  input logic wb_brdy_n_o
);
  AST_HOLD_BLOCKS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ahold_o |-> !snp_ready_o); // R2
  AST_PROBE_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eads_n_o |-> (ahold_o && $past(ahold_o) && addr_oe_o)); // R3
  AST_PROBE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !eads_n_o |=> eads_n_o); // R3
  AST_INV_ONLY_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_o |-> !eads_n_o); // R3
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_done_o |-> (!ahold_o && boff_n_o)); // R5
  AST_BOFF_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boff_n_o) |-> ($past(!hitm_n_i) && ahold_o)); // R6
  AST_BOFF_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !boff_n_o |=> boff_n_o); // R6
  AST_HOLD_DROP_AFTER_BOFF: assert property (@(posedge clk) disable iff (!rst_n)
    !boff_n_o |=> !ahold_o); // R7
  AST_WB_BRDY_FREE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_brdy_n_o |-> (!ahold_o && boff_n_o)); // R8
endmodule

bind snoop_backoff_ctrl snp_backoff_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .snp_ready_o (snp_ready_o),
  .snp_done_o  (snp_done_o),
  .hitm_n_i    (hitm_n_i),
  .ahold_o     (ahold_o),
  .eads_n_o    (eads_n_o),
  .inv_o       (inv_o),
  .addr_oe_o   (addr_oe_o),
  .boff_n_o    (boff_n_o),
  .wb_brdy_n_o (wb_brdy_n_o)
);

// File: tb/test_snoop_backoff_ctrl.sv
module test_snoop_backoff_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NVEC = 5;
  // fields: [10] hit, [9] open processor cycle, [8] invalidate, [7:0] address tag
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b1, 8'hA5},
    {1'b1, 1'b0, 1'b0, 8'h3C},
    {1'b0, 1'b1, 1'b1, 8'h81},
    {1'b0, 1'b0, 1'b0, 8'h7E},
    {1'b1, 1'b0, 1'b1, 8'hC3}
  };

  logic clk, rst_n;
  logic snp_req_i, snp_inv_i;
  logic [AW-1:0] snp_addr_i;
  logic snp_ready_o, snp_done_o, snp_hit_o;
  logic ads_n_i, blast_n_i, brdy_n_i, hitm_n_i;
  logic ahold_o, eads_n_o, inv_o, addr_oe_o, boff_n_o, wb_brdy_n_o;
  logic [AW-1:0] snp_addr_o;

  int total, fails;
  bit finished;

  snoop_backoff_ctrl #(.AW(AW)) i_snoop_backoff_ctrl (
    .clk(clk), .rst_n(rst_n),
    .snp_req_i(snp_req_i), .snp_addr_i(snp_addr_i), .snp_inv_i(snp_inv_i),
    .snp_ready_o(snp_ready_o), .snp_done_o(snp_done_o), .snp_hit_o(snp_hit_o),
    .ads_n_i(ads_n_i), .blast_n_i(blast_n_i), .brdy_n_i(brdy_n_i), .hitm_n_i(hitm_n_i),
    .ahold_o(ahold_o), .eads_n_o(eads_n_o), .inv_o(inv_o), .snp_addr_o(snp_addr_o),
    .addr_oe_o(addr_oe_o), .boff_n_o(boff_n_o), .wb_brdy_n_o(wb_brdy_n_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic run_snoop(input logic hit, input logic opn, input logic inv, input logic [7:0] tag);
    logic [AW-1:0] a;
    a = {24'h0, tag};
    if (opn) begin
      step(); ads_n_i = 1'b0;
      step(); ads_n_i = 1'b1;
    end
    step();
    chk("R2 ready before request", snp_ready_o, 1);
    snp_req_i = 1'b1; snp_addr_i = a; snp_inv_i = inv;
    step(); snp_req_i = 1'b0; snp_addr_i = '1;
    chk("R2 hold after accept", ahold_o, 1);
    chk("R2 ready low while busy", snp_ready_o, 0);
    chk("R3 no strobe in hold cycle 1", eads_n_o, 1);
    step();
    chk("R3 no strobe in hold cycle 2", eads_n_o, 1);
    chk("R3 inv quiet outside strobe", inv_o, 0);
    step();
    chk("R3 strobe in hold cycle 3", eads_n_o, 0);
    chk("R3 snoop address", snp_addr_o, a);
    chk("R3 address enable", addr_oe_o, 1);
    chk("R3 invalidate flag", inv_o, inv);
    step();
    chk("R3 strobe one clock", eads_n_o, 1);
    step(); hitm_n_i = ~hit;
    step(); hitm_n_i = 1'b1;
    if (!hit) begin
      chk("R5 done on miss", snp_done_o, 1);
      chk("R5 hit flag clear", snp_hit_o, 0);
      chk("R5 hold released", ahold_o, 0);
      chk("R5 no backoff", boff_n_o, 1);
      step();
      chk("R2 ready after done", snp_ready_o, 1);
      if (opn) begin
        brdy_n_i = 1'b0; blast_n_i = 1'b0;   // R9 processor burst completes
        step(); brdy_n_i = 1'b1; blast_n_i = 1'b1;
      end
      return;
    end
    if (opn) begin
      chk("R6 backoff after hit", boff_n_o, 0);
      chk("R6 hold kept during backoff", ahold_o, 1);
      step();
      chk("R6 backoff one clock", boff_n_o, 1);
      chk("R7 hold dropped after backoff", ahold_o, 0);
    end else begin
      chk("R10 R9 no backoff without open cycle", boff_n_o, 1);
      chk("R7 hold dropped after sample", ahold_o, 0);
    end
    chk("R7 no done yet", snp_done_o, 0);
    step();
    chk("R8 no ready before write-back strobe", wb_brdy_n_o, 1);
    ads_n_i = 1'b0;
    step(); ads_n_i = 1'b1;
    for (int b = 0; b < 4; b++) begin
      chk("R8 write-back beat ready", wb_brdy_n_o, 0);
      chk("R8 no done during beats", snp_done_o, 0);
      blast_n_i = (b == 3) ? 1'b0 : 1'b1;
      step();
    end
    blast_n_i = 1'b1;
    chk("R8 done after last beat", snp_done_o, 1);
    chk("R8 hit flag set", snp_hit_o, 1);
    chk("R8 beat ready ends", wb_brdy_n_o, 1);
    step();
    chk("R2 ready after done", snp_ready_o, 1);
  endtask

  initial begin
    total = 0; fails = 0; finished = 0;
    rst_n = 1'b0; snp_req_i = 1'b0; snp_addr_i = '0; snp_inv_i = 1'b0;
    ads_n_i = 1'b1; blast_n_i = 1'b1; brdy_n_i = 1'b1; hitm_n_i = 1'b1;
    step(); step();
    chk("R1 hold in reset", ahold_o, 0);
    chk("R1 strobe in reset", eads_n_o, 1);
    chk("R1 backoff in reset", boff_n_o, 1);
    chk("R1 ready in reset", snp_ready_o, 1);
    rst_n = 1'b1;
    step();
    chk("R1 beat ready after reset", wb_brdy_n_o, 1);
    chk("R1 done after reset", snp_done_o, 0);

    for (int v = 0; v < NVEC; v++)
      run_snoop(VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:0]);

    // R11 and R4: request while busy, hit reported in the wrong cycle
    step();
    snp_req_i = 1'b1; snp_addr_i = 32'h11; snp_inv_i = 1'b0;
    step(); snp_req_i = 1'b0;
    step(); snp_req_i = 1'b1; snp_addr_i = 32'h22; snp_inv_i = 1'b1;
    step(); snp_req_i = 1'b0;
    chk("R11 address kept", snp_addr_o, 32'h11);
    chk("R11 flag kept", inv_o, 0);
    step(); hitm_n_i = 1'b0;
    step(); hitm_n_i = 1'b1;
    step();
    chk("R4 early hit ignored", snp_hit_o, 0);
    chk("R4 done as miss", snp_done_o, 1);
    chk("R4 no backoff", boff_n_o, 1);
    step();
    chk("R11 no second snoop", ahold_o, 0);
    chk("R11 idle", snp_ready_o, 1);
    step();
    chk("R11 still idle", ahold_o, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule